// File: doc/BRIEF.md
# Host I/O Channel Register Decoder

This block is the host-facing register front end of a slave controller's I/O port. It receives host I/O cycles that are already decoded: a valid strobe, a read/write flag, a 16-bit address and a write byte. It routes each cycle to one of several byte channels, or to a window of sixteen two-way registers. Each byte channel has three registers. The host writes an input data register, and the slave reads it. The slave writes an output data register, and the host reads it. A status register reports the handshake state of both data registers.

On every host write to a channel, address bit 2 is latched as a command/data flag, so one data path carries both commands and data. On a host read of a channel, the same bit chooses between the output data register and the status register. The two-way register window takes its register index from the low address bits. Index 0 is split into two registers: the master-write register, which only the host writes, and the slave-write register, which only the slave writes. Channel base addresses and the window base are parameters.

Top module: `hostio_chan_decoder`

## Requirements
- R1: A host write that hits a channel stores `host_wdata` in that channel's input data register. The byte appears on `slv_idr_data[i]` from the next clock cycle.
- R2: Every host write to a channel latches address bit 2 into that channel's command/data flag. The flag is status bit 3, where 1 means command and 0 means data.
- R3: A host read of a channel with address bit 2 = 0 returns the output data register. With bit 2 = 1 it returns the status byte `{4'b0, cd, 1'b0, ibf, obf}` (bit 0 = output full, bit 1 = input full, bit 3 = command/data).
- R4: With the default parameters, channel 0 answers at 0x0060 and 0x0064, and channel 1 at 0x0062 and 0x0066. Channel 2 answers at 0x0CA2 and 0x0CA6. Every other address bit must match exactly, and bit 0 must be 0.
- R5: A host write to a channel sets its input-full bit. A pulse on `slv_idr_rd[i]` clears the bit. If both happen in the same cycle, the bit stays set.
- R6: A pulse on `slv_odr_we[i]` loads `slv_odr_wdata` and sets the output-full bit. A host read of the output data register clears the bit. If both happen in the same cycle, the bit stays set.
- R7: In the two-way window (0x0C80 to 0x0C8F by default), a host write with low nibble 0 loads the master-write register, which the slave reads at `slv_twr_idx` = 0. A host write with low nibble k (1 to 15) loads two-way register k, which the slave reads at index k.
- R8: In the two-way window, a host read with low nibble 0 returns the slave-write register, which the slave loads by writing index 0. A host read with low nibble k returns two-way register k, which the slave can also write.
- R9: A host cycle that matches no channel and no window drives `host_hit` low and `host_rdata` to 0, and changes no register.
- R10: After reset, the status bytes, the output data registers and all two-way registers are 0, and `host_hit` is low while `host_valid` is low. The input data registers have no reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host cycle present this clock |
| host_write | input | 1 | 1 = host write, 0 = host read |
| host_addr | input | 16 | Host I/O address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (0 when there is no read hit) |
| host_hit | output | 1 | The current host cycle matched a channel or the window |
| slv_idr_rd | input | 3 | Per-channel slave read strobe for the input data register |
| slv_idr_data | output | 3x8 | Per-channel input data register |
| slv_odr_we | input | 3 | Per-channel slave write strobe for the output data register |
| slv_odr_wdata | input | 8 | Slave byte for the output data registers |
| slv_status | output | 3x8 | Per-channel status byte |
| slv_twr_we | input | 1 | Slave write strobe for the two-way registers |
| slv_twr_idx | input | 4 | Slave two-way register index |
| slv_twr_wdata | input | 8 | Slave two-way write byte |
| slv_twr_rdata | output | 8 | Slave two-way read byte |

## Verification
The assertions check the following on every cycle:
- A channel write stores the byte, latches the command/data flag from bit 2 and sets input-full.
- A channel that was not written keeps its input register.
- Input-full clears after a slave read, and output-full clears after a host read, unless a set arrives in the same cycle.
- At most one target matches an address.
- Window writes land in the indexed register.
- A missed cycle returns no data.

Only the bench's scenarios can show the following:
- The exact address map, including the rejection of odd and unrelated addresses.
- The status byte layout seen by the host.
- The crossed index 0 of the window, where the host and the slave each read what the other wrote.
- Which side wins when set and clear collide.

// File: rtl/hostio_pkg.sv
package hostio_pkg;
   localparam int STAT_W  = 8;
   localparam int ST_OBF  = 0;
   localparam int ST_IBF  = 1;
   localparam int ST_CD   = 3;

   function automatic logic [STAT_W-1:0] pack_status(input logic obf,
                                                      input logic ibf,
                                                      input logic cd);
      logic [STAT_W-1:0] s;
      s         = '0;
      s[ST_OBF] = obf;
      s[ST_IBF] = ibf;
      s[ST_CD]  = cd;
      return s;
   endfunction
endpackage

// File: rtl/hostio_addr_dec.sv
module hostio_addr_dec #(
   parameter int ADDR_W = 16,
   parameter int NCH    = 3,
   parameter logic [NCH-1:0][ADDR_W-1:0] CH_BASE = '0,
   parameter logic [ADDR_W-1:0] TWR_BASE = '0,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   output logic [NCH-1:0]    ch_match,
   output logic              twr_match,
   output logic              cd_bit,
   output logic [IDX_W-1:0]  twr_idx
);
   // every bit except the command/data bit takes part in a channel match
   localparam logic [ADDR_W-1:0] CH_MASK = ~(ADDR_W'(1) << 2);

   if (ADDR_W < IDX_W + 1) begin : g_bad_w
      $error("ADDR_W too small for the register window index");
   end

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      if (CH_BASE[i][2] != 1'b0 || CH_BASE[i][0] != 1'b0) begin : g_bad_base
         $error("channel base must have bits 2 and 0 clear");
      end
      assign ch_match[i] = ((addr ^ CH_BASE[i]) & CH_MASK) == '0;
   end

   assign twr_match = addr[ADDR_W-1:IDX_W] == TWR_BASE[ADDR_W-1:IDX_W];
   assign cd_bit    = addr[2];
   assign twr_idx   = addr[IDX_W-1:0];

   // R4: an address selects at most one target
   p_single_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ch_match, twr_match}));
endmodule

// File: rtl/hostio_chan.sv
module hostio_chan #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd_odr,
   input  logic              cd_in,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              slv_idr_rd,
   input  logic              slv_odr_we,
   input  logic [DATA_W-1:0] slv_odr_wdata,
   output logic [DATA_W-1:0] idr_q,
   output logic [DATA_W-1:0] odr_q,
   output logic [hostio_pkg::STAT_W-1:0] status_q
);
   import hostio_pkg::*;

   logic ibf_q, obf_q, cd_q;

   // input data register: no reset value
   always_ff @(posedge clk) begin
      if (host_wr) idr_q <= host_wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         odr_q <= '0;
         ibf_q <= 1'b0;
         obf_q <= 1'b0;
         cd_q  <= 1'b0;
      end else begin
         if (host_wr) begin
            cd_q  <= cd_in;
            ibf_q <= 1'b1;
         end else if (slv_idr_rd) begin
            ibf_q <= 1'b0;
         end
         if (slv_odr_we) begin
            odr_q <= slv_odr_wdata;
            obf_q <= 1'b1;
         end else if (host_rd_odr) begin
            obf_q <= 1'b0;
         end
      end
   end

   assign status_q = pack_status(obf_q, ibf_q, cd_q);

   // R1, R2, R5: a host write lands with its flag and raises input-full
   p_host_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr |=> (idr_q == $past(host_wdata)) && status_q[ST_IBF]
                  && (status_q[ST_CD] == $past(cd_in)));
   // R9: the input register holds when it is not written
   p_idr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !host_wr |=> $stable(idr_q));
   // R5: a slave read with no competing write empties the buffer
   p_ibf_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      slv_idr_rd && !host_wr |=> !status_q[ST_IBF]);
   // R6: a host data read with no competing slave write empties the buffer
   p_obf_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd_odr && !slv_odr_we |=> !status_q[ST_OBF]);
endmodule

// File: rtl/hostio_twr.sv
module hostio_twr #(
   parameter int DATA_W = 8,
   parameter int NREG   = 16,
   localparam int IDX_W = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [IDX_W-1:0]  host_idx,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              slv_we,
   input  logic [IDX_W-1:0]  slv_idx,
   input  logic [DATA_W-1:0] slv_wdata,
   output logic [DATA_W-1:0] slv_rdata
);
   if (NREG < 2 || (1 << IDX_W) != NREG) begin : g_bad_n
      $error("NREG must be a power of two of at least 2");
   end

   // regs[0] is the host-only register; sw0_q is the slave-only register
   logic [DATA_W-1:0] regs [NREG];
   logic [DATA_W-1:0] sw0_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                        regs[0] <= '0;
      else if (host_we && host_idx == 0) regs[0] <= host_wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                      sw0_q <= '0;
      else if (slv_we && slv_idx == 0) sw0_q <= slv_wdata;
   end

   for (genvar k = 1; k < NREG; k++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)                                 regs[k] <= '0;
         else if (host_we && host_idx == IDX_W'(k))  regs[k] <= host_wdata;
         else if (slv_we && slv_idx == IDX_W'(k))    regs[k] <= slv_wdata;
      end
   end

   assign host_rdata = (host_idx == 0) ? sw0_q : regs[host_idx];
   assign slv_rdata  = regs[slv_idx];

   // R7: a host write reaches the indexed register
   p_twr_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
      host_we |=> regs[$past(host_idx)] == $past(host_wdata));
   // R8: a slave write to index 0 reaches the slave-only register
   p_sw0_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
      slv_we && slv_idx == 0 |=> sw0_q == $past(slv_wdata));
endmodule

// File: rtl/hostio_chan_decoder.sv
module hostio_chan_decoder #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int NCH    = 3,
   parameter logic [NCH-1:0][ADDR_W-1:0] CH_BASE = {16'h0CA2, 16'h0062, 16'h0060},
   parameter logic [ADDR_W-1:0] TWR_BASE = 16'h0C80,
   parameter int NTWR   = 16,
   localparam int IDX_W = $clog2(NTWR)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       host_valid,
   input  logic                       host_write,
   input  logic [ADDR_W-1:0]          host_addr,
   input  logic [DATA_W-1:0]          host_wdata,
   output logic [DATA_W-1:0]          host_rdata,
   output logic                       host_hit,
   input  logic [NCH-1:0]             slv_idr_rd,
   output logic [NCH-1:0][DATA_W-1:0] slv_idr_data,
   input  logic [NCH-1:0]             slv_odr_we,
   input  logic [DATA_W-1:0]          slv_odr_wdata,
   output logic [NCH-1:0][7:0]        slv_status,
   input  logic                       slv_twr_we,
   input  logic [IDX_W-1:0]           slv_twr_idx,
   input  logic [DATA_W-1:0]          slv_twr_wdata,
   output logic [DATA_W-1:0]          slv_twr_rdata
);
   if (DATA_W != hostio_pkg::STAT_W) begin : g_bad_dw
      $error("DATA_W must equal the status width");
   end

   logic [NCH-1:0]    ch_match;
   logic              twr_match, cd_bit;
   logic [IDX_W-1:0]  twr_idx;
   logic [DATA_W-1:0] twr_host_rdata;
   logic              host_rd, host_wr;
   logic [NCH-1:0][DATA_W-1:0] odr_q;

   assign host_rd = host_valid & ~host_write;
   assign host_wr = host_valid &  host_write;

   hostio_addr_dec #(
      .ADDR_W(ADDR_W), .NCH(NCH), .CH_BASE(CH_BASE),
      .TWR_BASE(TWR_BASE), .IDX_W(IDX_W)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .addr(host_addr),
      .ch_match(ch_match), .twr_match(twr_match),
      .cd_bit(cd_bit), .twr_idx(twr_idx)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_chan
      hostio_chan #(.DATA_W(DATA_W)) u_chan (
         .clk(clk), .rst_n(rst_n),
         .host_wr(host_wr & ch_match[i]),
         .host_rd_odr(host_rd & ch_match[i] & ~cd_bit),
         .cd_in(cd_bit),
         .host_wdata(host_wdata),
         .slv_idr_rd(slv_idr_rd[i]),
         .slv_odr_we(slv_odr_we[i]),
         .slv_odr_wdata(slv_odr_wdata),
         .idr_q(slv_idr_data[i]),
         .odr_q(odr_q[i]),
         .status_q(slv_status[i])
      );
   end

   hostio_twr #(.DATA_W(DATA_W), .NREG(NTWR)) u_twr (
      .clk(clk), .rst_n(rst_n),
      .host_we(host_wr & twr_match),
      .host_idx(twr_idx),
      .host_wdata(host_wdata),
      .host_rdata(twr_host_rdata),
      .slv_we(slv_twr_we),
      .slv_idx(slv_twr_idx),
      .slv_wdata(slv_twr_wdata),
      .slv_rdata(slv_twr_rdata)
   );

   always_comb begin
      host_rdata = '0;
      if (host_rd) begin
         if (twr_match) host_rdata = twr_host_rdata;
         for (int i = 0; i < NCH; i++) begin
            if (ch_match[i]) host_rdata = cd_bit ? slv_status[i] : odr_q[i];
         end
      end
   end

   assign host_hit = host_valid & (|ch_match | twr_match);

   // R9: a cycle outside every target returns nothing
   p_miss_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      host_valid && !host_hit |-> host_rdata == '0);
   // R10: no hit is reported without a host cycle
   p_idle_nohit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !host_valid |-> !host_hit);
endmodule

// File: tb/hostio_chan_decoder_tb.sv
module hostio_chan_decoder_tb;
   logic clk = 0;
   logic rst_n = 0;
   always #5 clk = ~clk;

   logic             host_valid = 0, host_write = 0;
   logic [15:0]      host_addr = 0;
   logic [7:0]       host_wdata = 0, host_rdata;
   logic             host_hit;
   logic [2:0]       slv_idr_rd = 0, slv_odr_we = 0;
   logic [2:0][7:0]  slv_idr_data, slv_status;
   logic [7:0]       slv_odr_wdata = 0;
   logic             slv_twr_we = 0;
   logic [3:0]       slv_twr_idx = 0;
   logic [7:0]       slv_twr_wdata = 0, slv_twr_rdata;

   hostio_chan_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_hit(host_hit), .slv_idr_rd(slv_idr_rd), .slv_idr_data(slv_idr_data),
      .slv_odr_we(slv_odr_we), .slv_odr_wdata(slv_odr_wdata), .slv_status(slv_status),
      .slv_twr_we(slv_twr_we), .slv_twr_idx(slv_twr_idx),
      .slv_twr_wdata(slv_twr_wdata), .slv_twr_rdata(slv_twr_rdata)
   );

   int checks = 0, errors = 0;
   bit done = 0;

   // scoreboard: expected {hit, data} per host read, with a requirement tag
   logic [8:0] exp_q [$];
   string      tag_q [$];

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (host_valid && !host_write) begin
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL scoreboard: actual read with no expected item, expected none");
         end else begin
            logic [8:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({host_hit, host_rdata} !== e) begin
               errors++;
               $display("FAIL %s: actual hit=%0b data=%02h expected hit=%0b data=%02h",
                        t, host_hit, host_rdata, e[8], e[7:0]);
            end
         end
      end
   end

   task automatic host_rd(input logic [15:0] a, input logic hit, input logic [7:0] d,
                          input string tag);
      exp_q.push_back({hit, d});
      tag_q.push_back(tag);
      @(posedge clk); #1;
      host_valid = 1; host_write = 0; host_addr = a;
      @(posedge clk); #1;
      host_valid = 0;
   endtask

   task automatic host_wr(input logic [15:0] a, input logic [7:0] d, input logic hit,
                          input string tag);
      @(posedge clk); #1;
      host_valid = 1; host_write = 1; host_addr = a; host_wdata = d;
      #3;
      checks++;
      if (host_hit !== hit) begin
         errors++;
         $display("FAIL %s: actual hit %0b expected %0b", tag, host_hit, hit);
      end
      @(posedge clk); #1;
      host_valid = 0; host_write = 0;
   endtask

   task automatic slv_idr_read(input int ch);
      @(posedge clk); #1;
      slv_idr_rd[ch] = 1;
      @(posedge clk); #1;
      slv_idr_rd = 0;
   endtask

   task automatic slv_odr_write(input int ch, input logic [7:0] d);
      @(posedge clk); #1;
      slv_odr_we[ch] = 1; slv_odr_wdata = d;
      @(posedge clk); #1;
      slv_odr_we = 0;
   endtask

   task automatic slv_twr_write(input logic [3:0] idx, input logic [7:0] d);
      @(posedge clk); #1;
      slv_twr_we = 1; slv_twr_idx = idx; slv_twr_wdata = d;
      @(posedge clk); #1;
      slv_twr_we = 0;
   endtask

   task automatic slv_twr_check(input logic [3:0] idx, input logic [7:0] exp,
                                input string tag);
      slv_twr_idx = idx; #1;
      chk(slv_twr_rdata, exp, tag);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(posedge clk); #1;
      // R10: reset state
      for (int i = 0; i < 3; i++) chk(slv_status[i], 8'h00, "R10 status reset");
      chk({7'b0, host_hit}, 8'h00, "R10 no hit when idle");
      slv_twr_check(4'd0, 8'h00, "R10 master-write reg reset");
      host_rd(16'h0064, 1, 8'h00, "R10 status via host");
      host_rd(16'h0C85, 1, 8'h00, "R10 two-way reg reset");
      host_rd(16'h0060, 1, 8'h00, "R10 output reg reset");

      // R1 R2 R5 R4: channel 0 data write
      host_wr(16'h0060, 8'hA5, 1, "R4 ch0 write hit");
      chk(slv_idr_data[0], 8'hA5, "R1 ch0 input reg");
      chk(slv_status[0], 8'h02, "R2 ch0 data flag, R5 ibf set");
      host_rd(16'h0064, 1, 8'h02, "R3 ch0 status read");

      // R4 R2: channel 1 command write at 0x66
      host_wr(16'h0066, 8'h3C, 1, "R4 ch1 write hit");
      chk(slv_idr_data[1], 8'h3C, "R1 ch1 input reg");
      host_rd(16'h0066, 1, 8'h0A, "R2 ch1 command flag");
      chk(slv_idr_data[0], 8'hA5, "R4 ch0 untouched by ch1");

      // R4: channel 2 at its base
      host_wr(16'h0CA6, 8'h77, 1, "R4 ch2 cmd write");
      chk(slv_idr_data[2], 8'h77, "R1 ch2 input reg");
      chk(slv_status[2], 8'h0A, "R2 ch2 command flag");
      host_wr(16'h0CA2, 8'h11, 1, "R4 ch2 data write");
      chk(slv_status[2], 8'h02, "R2 ch2 flag back to data");

      // R5: slave read clears, collision keeps set
      slv_idr_read(0);
      chk(slv_status[0], 8'h00, "R5 ibf cleared by slave read");
      @(posedge clk); #1;
      host_valid = 1; host_write = 1; host_addr = 16'h0064; host_wdata = 8'hE1;
      slv_idr_rd[0] = 1;
      @(posedge clk); #1;
      host_valid = 0; host_write = 0; slv_idr_rd = 0;
      chk(slv_status[0], 8'h0A, "R5 set wins over clear");
      chk(slv_idr_data[0], 8'hE1, "R1 ch0 collision byte");

      // R6 R3: output register handshake
      slv_odr_write(1, 8'h5A);
      chk(slv_status[1], 8'h0B, "R6 obf set by slave write");
      host_rd(16'h0062, 1, 8'h5A, "R3 ch1 output data read");
      host_rd(16'h0066, 1, 8'h0A, "R6 obf cleared by host read");
      slv_odr_write(1, 8'h6B);
      @(posedge clk); #1;
      exp_q.push_back({1'b1, 8'h6B}); tag_q.push_back("R6 collision read data");
      host_valid = 1; host_write = 0; host_addr = 16'h0062;
      slv_odr_we[1] = 1; slv_odr_wdata = 8'h7C;
      @(posedge clk); #1;
      host_valid = 0; slv_odr_we = 0;
      chk(slv_status[1], 8'h0B, "R6 set wins over clear");
      host_rd(16'h0062, 1, 8'h7C, "R6 new output byte");

      // R9: misses change nothing
      host_wr(16'h0061, 8'hFF, 0, "R9 odd address miss");
      host_wr(16'h0CA3, 8'hFF, 0, "R9 ch2 odd miss");
      host_wr(16'h0070, 8'hFF, 0, "R9 unrelated write miss");
      chk(slv_idr_data[0], 8'hE1, "R9 ch0 unchanged");
      chk(slv_idr_data[2], 8'h11, "R9 ch2 unchanged");
      chk(slv_status[0], 8'h0A, "R9 ch0 status unchanged");
      host_rd(16'h0068, 0, 8'h00, "R9 read miss");
      host_rd(16'h0C90, 0, 8'h00, "R9 past window miss");

      // R7 R8: two-way window
      host_wr(16'h0C80, 8'h91, 1, "R7 master-write hit");
      slv_twr_check(4'd0, 8'h91, "R7 slave sees master-write reg");
      host_rd(16'h0C80, 1, 8'h00, "R8 host idx0 reads slave-write reg");
      slv_twr_write(4'd0, 8'hC3);
      host_rd(16'h0C80, 1, 8'hC3, "R8 slave-write reg to host");
      slv_twr_check(4'd0, 8'h91, "R7 master-write reg kept");
      slv_twr_write(4'd5, 8'h66);
      host_rd(16'h0C85, 1, 8'h66, "R8 slave write reg5 to host");
      for (int k = 1; k < 16; k++) host_wr(16'h0C80 | 16'(k), 8'(k * 3 + 1), 1, "R7 window write");
      for (int k = 1; k < 16; k++) host_rd(16'h0C80 | 16'(k), 1, 8'(k * 3 + 1), "R8 window read back");
      slv_twr_check(4'd15, 8'd46, "R7 reg15 to slave");
      slv_twr_check(4'd5, 8'd16, "R7 reg5 overwritten by host");

      repeat (3) @(posedge clk);
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: actual %0d items left expected 0", exp_q.size());
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule